// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the synchronized levels of a 32-pin GPIO port into per-pin pending flags, one combined interrupt request and a wake request for the power manager. Each pin has its own settings. It can sense a level or an edge. Its polarity picks high/rising or low/falling. A both-edges override applies in edge mode. Separate masks decide whether a pin can interrupt and whether it can wake.

Pending flags are sticky. Software reads them on `pend` and removes them by pulsing `clr_stb` with a one in `clr_mask` for each flag to drop. Register decoding sits outside the block. All settings arrive as plain vectors, one bit per pin.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst_n` is low, `pend`, `irq` and `wake` are all 0. In the first clock cycle after reset is released, edge detection is suppressed, so a pin that is already high or low causes no edge event.
- R2: With `mode` bit = 0 (level sensing), the flag of that pin is set on every clock edge at which its level is active. The active level is high when `pol` = 1 and low when `pol` = 0.
- R3: With `mode` bit = 1 and `dual` bit = 0, the flag is set at the clock edge where the level differs from the level sampled one cycle earlier. With `pol` = 1 this is a 0→1 change; with `pol` = 0 it is a 1→0 change. The opposite transition and an unchanged level set nothing.
- R4: With `mode` = 1 and `dual` = 1, both transitions set the flag whatever `pol` is. In level mode, `dual` has no effect.
- R5: A flag set by an event stays 1 until cleared. At a clock edge with `clr_stb` = 1, each flag whose `clr_mask` bit is 1 is cleared and the other flags are kept. With `clr_stb` = 0, `clr_mask` is ignored.
- R6: When an event and a clear hit the same bit at the same edge, the flag stays 1. A level-mode pin held at its active level therefore cannot be cleared.
- R7: `irq` is registered. One clock after any bit of `pend & irq_en` is 1, `irq` is 1; otherwise it is 0.
- R8: `wake` is registered. It is 1 exactly in the cycle after a clock edge at which some pin had an event with its `wake_en` bit = 1, at the same edge where that pin's flag is set. The events that count are those of R2–R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| mode | input | 32 | Per pin: 0 level sensing, 1 edge sensing |
| pol | input | 32 | Per pin: 1 high/rising, 0 low/falling |
| dual | input | 32 | Per pin: 1 catches both edges in edge mode |
| irq_en | input | 32 | Per pin interrupt enable |
| wake_en | input | 32 | Per pin wake enable |
| clr_stb | input | 1 | Clear strobe for pending flags |
| clr_mask | input | 32 | Ones select flags to clear |
| pend | output | 32 | Pending flags |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wake request to the power manager |

## Verification
The hardest case to reach is an event and a clear landing on the same flag at the same clock edge. The pin level must change on the exact cycle the clear strobe is high. The bench drives the new level and the clear mask at the same falling edge, so both reach the same rising edge.

A second hard case is the first cycle after reset with pins already high, where a naive design reports a false edge. The bench holds all pins high through reset to probe it.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  // One pin: does the current sample constitute an event?
  function automatic logic pin_hit(input logic edge_md, input logic hi_act,
                                   input logic both, input logic cur,
                                   input logic last, input logic armed);
    logic up, down;
    if (!edge_md) return hi_act ? cur : ~cur;
    if (!armed) return 1'b0;
    up   = cur & ~last;
    down = ~cur & last;
    if (both) return up | down;
    return hi_act ? up : down;
  endfunction

  // Next flag vector: clear first, then events override.
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] kill,
                                            input logic [31:0] hits);
    return (cur & ~kill) | hits;
  endfunction

endpackage

// File: rtl/gpio_irq_edge.sv
`timescale 1ns/1ps
module gpio_irq_edge #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] mode,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] dual,
  output logic [NPIN-1:0] evt
);
  import gpio_irq_pkg::*;

  logic [NPIN-1:0] last_q;
  logic            armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      last_q  <= lvl;
      armed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign evt[g] = pin_hit(mode[g], pol[g], dual[g], lvl[g], last_q[g], armed_q);
  end

  // R1: no edge-mode event before the previous level is known
  p_no_early_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> ((evt & mode) == '0));

endmodule

// File: rtl/gpio_irq_flags.sv
`timescale 1ns/1ps
module gpio_irq_flags #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] evt,
  input  logic            clr_stb,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] pend
);
  import gpio_irq_pkg::*;

  logic [NPIN-1:0] kill;
  logic [NPIN-1:0] pend_q;

  assign kill = clr_stb ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= flag_next(pend_q, kill, evt);
  end

  assign pend = pend_q;

  // R5: a flag not selected for clearing is kept
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~kill)) == $past(pend_q & ~kill)));

  // R5: a flag only rises because of an event
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));

  // R6: an event wins over a simultaneous clear
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/gpio_irq_out.sv
`timescale 1ns/1ps
module gpio_irq_out #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pend,
  input  logic [NPIN-1:0] irq_en,
  input  logic [NPIN-1:0] evt,
  input  logic [NPIN-1:0] wake_en,
  output logic            irq,
  output logic            wake
);
  logic irq_q, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= |(pend & irq_en);
      wake_q <= |(evt & wake_en);
    end
  end

  assign irq  = irq_q;
  assign wake = wake_q;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_lvl,
  input  logic [NPIN-1:0] mode,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] dual,
  input  logic [NPIN-1:0] irq_en,
  input  logic [NPIN-1:0] wake_en,
  input  logic            clr_stb,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] pend,
  output logic            irq,
  output logic            wake
);
  logic [NPIN-1:0] evt;

  gpio_irq_edge #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .mode(mode), .pol(pol),
    .dual(dual), .evt(evt)
  );

  gpio_irq_flags #(.NPIN(NPIN)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .pend(pend)
  );

  gpio_irq_out #(.NPIN(NPIN)) u_out (
    .clk(clk), .rst_n(rst_n), .pend(pend), .irq_en(irq_en), .evt(evt),
    .wake_en(wake_en), .irq(irq), .wake(wake)
  );

  // R1: outputs quiet while reset is held
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (pend == '0 && !irq && !wake);
    end
  end

  // R7: interrupt follows the enabled flags one cycle later
  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend & irq_en))));

  // R8: wake follows enabled events one cycle later
  p_wake_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wake == $past(|(evt & wake_en))));

endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_lvl, mode, pol, dual, irq_en, wake_en, clr_mask;
  logic        clr_stb;
  logic [31:0] pend;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  gpio_irq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .mode(mode), .pol(pol),
    .dual(dual), .irq_en(irq_en), .wake_en(wake_en), .clr_stb(clr_stb),
    .clr_mask(clr_mask), .pend(pend), .irq(irq), .wake(wake)
  );

  // {mode, pol, dual, level before, level after, expected event}
  localparam logic [5:0] VEC [12] = '{
    6'b110_01_1, 6'b110_10_0, 6'b100_10_1, 6'b100_01_0,
    6'b101_01_1, 6'b111_10_1, 6'b111_11_0, 6'b010_01_1,
    6'b010_00_0, 6'b000_10_1, 6'b000_11_0, 6'b011_00_0
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_all(input logic m, input logic p, input logic d);
    mode = {32{m}};
    pol  = {32{p}};
    dual = {32{d}};
  endtask

  task automatic clear_all();
    clr_stb = 1'b1; clr_mask = '1;
    step(); step();
    clr_stb = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_lvl = '1; cfg_all(1'b1, 1'b1, 1'b0);
    irq_en = '1; wake_en = '1; clr_stb = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset pend", pend, '0);
    chk("R1 reset irq/wake", {30'd0, irq, wake}, '0);
    rst_n = 1'b1;
    step(); step();
    chk("R1 no false edge pend", pend, '0);
    chk("R1 no false edge wake", {31'd0, wake}, '0);

    // Table walk: all pins share config and level
    irq_en = '0;
    foreach (VEC[i]) begin
      cfg_all(VEC[i][5], VEC[i][4], VEC[i][3]);
      pin_lvl = {32{VEC[i][2]}};
      clr_stb = 1'b1; clr_mask = '1;
      step(); step();
      clr_stb = 1'b0; clr_mask = '0;
      pin_lvl = {32{VEC[i][1]}};
      step();
      if (!VEC[i][5])     chk("R2 level sensing", pend, {32{VEC[i][0]}});
      else if (VEC[i][3]) chk("R4 dual edge", pend, {32{VEC[i][0]}});
      else                chk("R3 edge polarity", pend, {32{VEC[i][0]}});
      chk("R8 wake on event", {31'd0, wake}, {31'd0, VEC[i][0]});
    end

    // R7: interrupt gating and latency
    cfg_all(1'b1, 1'b1, 1'b0);
    pin_lvl = '0;
    clear_all();
    pin_lvl = 32'h0000_0008;
    step();
    chk("R3 single rise", pend, 32'h0000_0008);
    step();
    chk("R7 irq masked", {31'd0, irq}, '0);
    irq_en = 32'h0000_0200;
    step();
    chk("R7 other enable", {31'd0, irq}, '0);
    irq_en = 32'h0000_0008;
    step();
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    clr_stb = 1'b1; clr_mask = 32'h0000_0008;
    step();
    clr_stb = 1'b0; clr_mask = '0;
    chk("R5 cleared bit", pend, '0);
    chk("R7 irq lags clear", {31'd0, irq}, 32'd1);
    step();
    chk("R7 irq dropped", {31'd0, irq}, '0);

    // R5: selective clear, strobe gating
    pin_lvl = 32'h0000_0080;
    step();
    pin_lvl = 32'h0000_1080;
    step();
    chk("R5 two flags", pend, 32'h0000_1080);
    clr_mask = '1;
    step();
    chk("R5 mask without strobe", pend, 32'h0000_1080);
    clr_stb = 1'b1; clr_mask = 32'h0000_1000;
    step();
    clr_stb = 1'b0; clr_mask = '0;
    chk("R5 selective clear", pend, 32'h0000_0080);

    // R6: event and clear on the same edge
    clr_stb = 1'b1; clr_mask = 32'h0000_0084;
    pin_lvl = 32'h0000_1084;
    step();
    clr_stb = 1'b0; clr_mask = '0;
    chk("R6 event beats clear", pend, 32'h0000_0004);

    // R6: level-mode flag cannot be cleared while active
    cfg_all(1'b0, 1'b1, 1'b0);
    step();
    chk("R2 level flags", pend, 32'h0000_1084);
    clr_stb = 1'b1; clr_mask = '1;
    step();
    chk("R6 level persists", pend, 32'h0000_1084);
    pin_lvl = '0;
    step();
    clr_stb = 1'b0; clr_mask = '0;
    chk("R5 level clear after release", pend, '0);

    // R8: wake gating and pulse width
    cfg_all(1'b1, 1'b1, 1'b0);
    step(); step();
    wake_en = 32'h0010_0000;
    pin_lvl = 32'h0000_0020;
    step();
    chk("R8 wake gated off", {31'd0, wake}, '0);
    chk("R8 flag still set", pend, 32'h0000_0020);
    pin_lvl = 32'h0010_0020;
    step();
    chk("R8 wake enabled", {31'd0, wake}, 32'd1);
    step();
    chk("R8 wake single pulse", {31'd0, wake}, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule